// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock with Alarm

This block keeps wall-clock time as one 47-bit count. The upper 32 bits hold whole seconds and the lower 15 bits hold the fraction of a second. A single-cycle `tick_i` strobe at 32.768 kHz advances the count. Software reaches the block through a small register port: a byte address, a write strobe, write data, and read data that is returned one cycle later. A 47-bit alarm value is compared with the count. When they match, a sticky flag is raised, and that flag can be routed to one level-sensitive interrupt line.

Two guards keep the clock from running on stale data after reset. First, the count stays frozen until software has written the seconds word at least once, even if the enable bit is already set. Second, the status word comes out of reset with a not-valid bit and a security bit set, and software must clear both. The reset alarm seconds value is all ones, which acts as "no alarm" because the count never gets there in service.

Top module: `tick_rtc`

## Requirements
- R1: After reset the seconds and fraction read 0. Alarm seconds reads 0xFFFFFFFF and alarm fraction reads 0. Control and interrupt-enable read 0, status reads 0x3, and `irq_o` is 0.
- R2: Register map by byte address: seconds 0x00, fraction 0x04 (zero-extended), alarm seconds 0x08, alarm fraction 0x0C, control 0x10, status 0x14, interrupt enable 0x18. `rdata_o` shows the selected register one clock after `addr_i` is presented. Any other address reads 0.
- R3: The count goes up by one on each clock where `tick_i` is high, provided control bit 3 (run) is set and the seconds word has been written. While the run bit is clear, ticks leave the count unchanged.
- R4: After reset the count does not move until the seconds word is written. A write of zero counts as that first write.
- R5: When the 15-bit fraction is at 0x7FFF, a tick wraps it to 0 and adds one to the seconds.
- R6: A write to either time word takes effect on the clock of the write. The written word loads, the other word holds, and a tick in that same cycle is dropped, so no carry occurs.
- R7: Status bit 4 (alarm) sets on the clock where the count advances to a value equal to the 47-bit alarm seconds:fraction. Writing the time so that it equals the alarm does not set it.
- R8: The alarm flag stays set until software writes 1 to status bit 4. Further ticks do not clear it.
- R9: Status bit 1 (not valid) and bit 0 (security) each clear when 1 is written to that bit. Writing 0 to them has no effect, and once cleared they stay clear.
- R10: `irq_o` is registered and equals the alarm flag AND interrupt-enable bit 4, one clock later.
- R11: Only control bit 3 and interrupt-enable bit 4 are stored. All other bits of those registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle 32.768 kHz advance strobe |
| addr_i | input | 5 | Byte address of register |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Alarm interrupt, level |

## Verification
Register writes and count advances take effect at the clock edge that samples them. A read result appears one edge after the address is driven. `irq_o` trails the flag and the enable by a further edge.

Each expected item in the scoreboard carries the cycle number at which it becomes due. The monitor compares items only on the falling edge of that cycle or a later one. Read results are due one edge after the driver pushes them. Interrupt checks are made only after at least two edges have passed since the write that caused the change.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SEC_W  = 32;
  localparam int FRAC_W = 15;
  localparam int CNT_W  = SEC_W + FRAC_W;

  // word index = byte address / 4
  localparam logic [2:0] IDX_SEC   = 3'd0;
  localparam logic [2:0] IDX_FRAC  = 3'd1;
  localparam logic [2:0] IDX_ASEC  = 3'd2;
  localparam logic [2:0] IDX_AFRAC = 3'd3;
  localparam logic [2:0] IDX_CTRL  = 3'd4;
  localparam logic [2:0] IDX_STAT  = 3'd5;
  localparam logic [2:0] IDX_IEN   = 3'd6;

  localparam int BIT_RUN   = 3;
  localparam int BIT_ALARM = 4;
  localparam int BIT_NVAL  = 1;
  localparam int BIT_SECV  = 0;
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15,
  localparam int CNT_W = SEC_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run_en,
  input  logic              wr_sec,
  input  logic              wr_frac,
  input  logic [SEC_W-1:0]  wsec,
  input  logic [FRAC_W-1:0] wfrac,
  output logic [SEC_W-1:0]  sec,
  output logic [FRAC_W-1:0] frac,
  output logic              adv,
  output logic [CNT_W-1:0]  cnt_nxt
);
  logic started;
  logic wr_any;

  assign wr_any  = wr_sec | wr_frac;
  assign adv     = tick & run_en & started & ~wr_any;
  assign cnt_nxt = {sec, frac} + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec     <= '0;
      frac    <= '0;
      started <= 1'b0;
    end else if (wr_any) begin
      if (wr_sec) begin
        sec     <= wsec;
        started <= 1'b1;
      end
      if (wr_frac) frac <= wfrac;
    end else if (adv) begin
      {sec, frac} <= cnt_nxt;
    end
  end

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!(tick && run_en) && !wr_sec && !wr_frac) |=> $stable({sec, frac}));

  // R4
  frozen_before_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!started && !wr_sec && !wr_frac) |=> $stable({sec, frac}));

  // R6
  frac_write_no_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_frac && !wr_sec) |=> $stable(sec));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15,
  localparam int CNT_W = SEC_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sec,
  input  logic              wr_frac,
  input  logic [SEC_W-1:0]  wsec,
  input  logic [FRAC_W-1:0] wfrac,
  input  logic              adv,
  input  logic [CNT_W-1:0]  cnt_nxt,
  input  logic              clr,
  output logic [SEC_W-1:0]  asec,
  output logic [FRAC_W-1:0] afrac,
  output logic              flag
);
  logic hit;

  assign hit = adv && (cnt_nxt == {asec, afrac});

  always_ff @(posedge clk) begin
    if (rst) begin
      asec  <= '1;
      afrac <= '0;
      flag  <= 1'b0;
    end else begin
      if (wr_sec)  asec  <= wsec;
      if (wr_frac) afrac <= wfrac;
      flag <= hit | (flag & ~clr);
    end
  end

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/tick_rtc.sv
module tick_rtc #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  import rtc_pkg::*;

  logic              sel_ok;
  logic [2:0]        idx;
  logic              w_sec, w_frac, w_asec, w_afrac, w_ctrl, w_stat, w_ien;
  logic              run_en, ien, nval, secv;
  logic [SEC_W-1:0]  sec, asec;
  logic [FRAC_W-1:0] frac, afrac;
  logic              adv, flag;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [DATA_W-1:0] rd_mux;

  assign sel_ok  = (addr_i[1:0] == 2'b00) && (addr_i[ADDR_W-1:5] == '0);
  assign idx     = addr_i[4:2];
  assign w_sec   = wr_i && sel_ok && idx == IDX_SEC;
  assign w_frac  = wr_i && sel_ok && idx == IDX_FRAC;
  assign w_asec  = wr_i && sel_ok && idx == IDX_ASEC;
  assign w_afrac = wr_i && sel_ok && idx == IDX_AFRAC;
  assign w_ctrl  = wr_i && sel_ok && idx == IDX_CTRL;
  assign w_stat  = wr_i && sel_ok && idx == IDX_STAT;
  assign w_ien   = wr_i && sel_ok && idx == IDX_IEN;

  rtc_timebase #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_tb (
    .clk(clk), .rst(rst), .tick(tick_i), .run_en(run_en),
    .wr_sec(w_sec), .wr_frac(w_frac),
    .wsec(wdata_i[SEC_W-1:0]), .wfrac(wdata_i[FRAC_W-1:0]),
    .sec(sec), .frac(frac), .adv(adv), .cnt_nxt(cnt_nxt)
  );

  rtc_alarm #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_alm (
    .clk(clk), .rst(rst), .wr_sec(w_asec), .wr_frac(w_afrac),
    .wsec(wdata_i[SEC_W-1:0]), .wfrac(wdata_i[FRAC_W-1:0]),
    .adv(adv), .cnt_nxt(cnt_nxt), .clr(w_stat && wdata_i[BIT_ALARM]),
    .asec(asec), .afrac(afrac), .flag(flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_en <= 1'b0;
      ien    <= 1'b0;
      nval   <= 1'b1;
      secv   <= 1'b1;
      irq_o  <= 1'b0;
    end else begin
      if (w_ctrl) run_en <= wdata_i[BIT_RUN];
      if (w_ien)  ien    <= wdata_i[BIT_ALARM];
      if (w_stat && wdata_i[BIT_NVAL]) nval <= 1'b0;
      if (w_stat && wdata_i[BIT_SECV]) secv <= 1'b0;
      irq_o <= flag & ien;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ok) begin
      unique case (idx)
        IDX_SEC:   rd_mux = DATA_W'(sec);
        IDX_FRAC:  rd_mux = DATA_W'(frac);
        IDX_ASEC:  rd_mux = DATA_W'(asec);
        IDX_AFRAC: rd_mux = DATA_W'(afrac);
        IDX_CTRL:  rd_mux[BIT_RUN] = run_en;
        IDX_STAT: begin
          rd_mux[BIT_ALARM] = flag;
          rd_mux[BIT_NVAL]  = nval;
          rd_mux[BIT_SECV]  = secv;
        end
        IDX_IEN:   rd_mux[BIT_ALARM] = ien;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end

  // R7
  alarm_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> ({sec, frac} == {asec, afrac}));

  // R10
  irq_follows_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(flag && ien));

  // R9
  nval_stays_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !nval |=> !nval);
endmodule

// File: tb/tb_tick_rtc.sv
module tb_tick_rtc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  tick_rtc dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .addr_i(addr_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    int unsigned due;
    string       tag;
    logic [4:0]  addr;
  } item_t;

  item_t       sb[$];
  int unsigned cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares items that have come due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (it.is_irq) begin
        if (irq_o !== it.exp[0]) begin
          errors++;
          $display("FAIL %s irq: got %0b exp %0b", it.tag, irq_o, it.exp[0]);
        end
      end else if (rdata_o !== it.exp) begin
        errors++;
        $display("FAIL %s addr 0x%02h: got 0x%08h exp 0x%08h",
                 it.tag, it.addr, rdata_o, it.exp);
      end
    end
  end

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    item_t it;
    @(negedge clk);
    addr_i = a;
    it.is_irq = 0; it.exp = e; it.due = cyc + 1; it.tag = t; it.addr = a;
    sb.push_back(it);
  endtask

  task automatic chk_irq(input bit e, input string t);
    item_t it;
    @(negedge clk);
    it.is_irq = 1; it.exp = {31'd0, e}; it.due = cyc + 1; it.tag = t; it.addr = '0;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input bit with_tick);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_i = 1'b1; tick_i = with_tick;
    @(negedge clk);
    wr_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R2 map
    rd(5'h00, 32'h0, "R1");
    rd(5'h04, 32'h0, "R1");
    rd(5'h08, 32'hFFFF_FFFF, "R1");
    rd(5'h0C, 32'h0, "R1");
    rd(5'h10, 32'h0, "R1");
    rd(5'h14, 32'h3, "R1");
    rd(5'h18, 32'h0, "R1");
    chk_irq(1'b0, "R1");
    rd(5'h1C, 32'h0, "R2");
    rd(5'h02, 32'h0, "R2");

    // R11 only run bit kept; R4 frozen before first seconds write
    wr(5'h10, 32'hFFFF_FFFF, 0);
    rd(5'h10, 32'h8, "R11");
    ticks(5);
    rd(5'h04, 32'h0, "R4");

    // R4 write of zero starts it; R3 advance
    wr(5'h00, 32'h0, 0);
    ticks(3);
    rd(5'h04, 32'h3, "R3");
    rd(5'h00, 32'h0, "R3");

    // R3 run bit clear blocks ticks
    wr(5'h10, 32'h0, 0);
    ticks(4);
    rd(5'h04, 32'h3, "R3");
    wr(5'h10, 32'h8, 0);

    // R5 fraction wrap
    wr(5'h04, 32'h7FFE, 0);
    ticks(2);
    rd(5'h00, 32'h1, "R5");
    rd(5'h04, 32'h0, "R5");

    // R6 write during tick: no advance, no carry
    wr(5'h04, 32'h7FFF, 1);
    rd(5'h04, 32'h7FFF, "R6");
    rd(5'h00, 32'h1, "R6");
    ticks(1);
    rd(5'h00, 32'h2, "R5");
    rd(5'h04, 32'h0, "R5");

    // R9 W1C of status bits
    wr(5'h14, 32'h0, 0);
    rd(5'h14, 32'h3, "R9");
    wr(5'h14, 32'h1, 0);
    rd(5'h14, 32'h2, "R9");
    wr(5'h14, 32'h2, 0);
    rd(5'h14, 32'h0, "R9");

    // R7 alarm at 2:5
    wr(5'h08, 32'h2, 0);
    wr(5'h0C, 32'h5, 0);
    rd(5'h08, 32'h2, "R2");
    rd(5'h0C, 32'h5, "R2");
    wr(5'h18, 32'hFFFF_FFFF, 0);
    rd(5'h18, 32'h10, "R11");
    ticks(4);
    rd(5'h14, 32'h0, "R7");
    chk_irq(1'b0, "R10");
    ticks(1);
    rd(5'h04, 32'h5, "R7");
    rd(5'h14, 32'h10, "R7");
    chk_irq(1'b1, "R10");

    // R8 sticky across ticks
    ticks(3);
    rd(5'h14, 32'h10, "R8");
    rd(5'h04, 32'h8, "R8");

    // R10 enable gating
    wr(5'h18, 32'h0, 0);
    chk_irq(1'b0, "R10");
    wr(5'h18, 32'h10, 0);
    chk_irq(1'b1, "R10");

    // R8 W1C of alarm flag
    wr(5'h14, 32'h10, 0);
    rd(5'h14, 32'h0, "R8");
    chk_irq(1'b0, "R10");

    // R7 write equal to alarm does not set
    wr(5'h04, 32'h5, 0);
    rd(5'h04, 32'h5, "R7");
    rd(5'h14, 32'h0, "R7");
    chk_irq(1'b0, "R7");

    repeat (4) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule